// File: doc/BRIEF.md
# Round-Robin Conversion Sequencer

This block decides when an external successive-approximation converter begins a conversion and which analog channel it samples. Software-side logic hands it a one-shot start request, a continuous-mode level, an optional pacing tick from an external rate divider and a per-channel enable mask. The sequencer holds the channel select and drives a start/done handshake toward the converter. When a conversion finishes it latches the result and error status and emits a one-cycle sample pulse for a downstream FIFO.

When the mask is non-zero, each conversion uses the channel held in the select. After the conversion completes, the select advances to the next enabled channel. The search goes upward and wraps around. One-shot and continuous starts are arbitrated against each other. A plain enable input gates the whole block. Clearing it drops any pending request and abandons a conversion in flight.

Top module: `conv_sequencer`

## Requirements
- R1: With `rr_mask` all zero, the select `chan_sel` is unchanged by a completed conversion.
- R2: With a non-zero mask, a conversion samples the channel in `chan_sel` (shown on `conv_chan` while `conv_start` is high). On completion `chan_sel` becomes the first channel with a set mask bit found by counting upward from the converted channel plus one, modulo 9. A mask with a single set bit repeats that channel.
- R3: A one-shot request starts exactly one conversion. A request made while a conversion is running is held and starts one conversion when the converter is free. A request made while `continuous` is 1 is ignored.
- R4: With `continuous` at 1 and `pace_active` at 0, `conv_start` is asserted in the cycle right after a completion is accepted.
- R5: With `continuous` and `pace_active` both at 1, a conversion starts only on a `pace_tick`. A tick that arrives during a conversion is kept and starts the next conversion as soon as the current one completes.
- R6: `ready` is 0 during reset and from the cycle after `conv_start` until the completion is accepted. It is 1 when the block is enabled and idle. `conv_start` is only asserted while `ready` is 1.
- R7: `last_result` and `last_err` hold the 12-bit value and error bit of the most recent completed conversion only.
- R8: `err_sticky` is set by any completion with the error bit set and is cleared by an `err_clr` pulse. If both happen in the same cycle, the set wins.
- R9: While `enable` is 0, `conv_start` and `ready` are 0 and a running conversion is abandoned. Pending one-shot requests and ticks are dropped and do not start a conversion after re-enable.
- R10: Each accepted completion produces a `smp_valid` pulse lasting exactly one cycle, carrying the result, error bit and converted channel.
- R11: `conv_done` is ignored when no conversion is in progress.
- R12: A `sel_wr` pulse loads `chan_sel`. If a completion with a non-zero mask is accepted in the same cycle, the round-robin step wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable / power gate |
| continuous | input | 1 | Continuous conversion mode |
| oneshot_req | input | 1 | Single conversion request pulse |
| pace_active | input | 1 | Pacing divider is non-zero |
| pace_tick | input | 1 | Pacing tick pulse |
| rr_mask | input | 9 | Round-robin channel enable mask |
| sel_wr | input | 1 | Load channel select |
| sel_wr_data | input | 4 | Channel select value to load |
| err_clr | input | 1 | Clear sticky error |
| conv_start | output | 1 | Start pulse to converter |
| conv_chan | output | 4 | Channel presented to the converter |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | 12 | Converter result |
| conv_err | input | 1 | Converter error for this result |
| ready | output | 1 | Idle and able to start |
| chan_sel | output | 4 | Current channel select |
| last_result | output | 12 | Most recent result |
| last_err | output | 1 | Most recent error bit |
| err_sticky | output | 1 | Any past error |
| smp_valid | output | 1 | Sample pulse |
| smp_result | output | 12 | Sample result |
| smp_err | output | 1 | Sample error bit |
| smp_chan | output | 4 | Sample channel |

## Verification
Two pairs of functions can collide in one cycle. The first is a completion carrying an error bit and a sticky-clear pulse. The second is a completion with a non-zero mask and a software select write. The bench drives `conv_done` together with `err_clr` in one case and with `sel_wr` in another, then reads `err_sticky` and `chan_sel` one cycle later to confirm that the set and the round-robin step win. It also lands a continuous-mode restart in the same cycle as a completion and checks that `conv_start` is high in the very next cycle on the stepped channel.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int MAX_CH = 16;

  // Upward search with wraparound for the next enabled channel (R2).
  function automatic logic [7:0] rr_next(input logic [MAX_CH-1:0] mask,
                                         input logic [7:0] cur,
                                         input int unsigned n);
    logic [7:0] r;
    logic found;
    int unsigned c;
    r = cur;
    found = 1'b0;
    for (int i = 1; i <= MAX_CH; i++) begin
      c = (32'(cur) + 32'(i)) % n;
      if (!found && (32'(i) <= n) && mask[c]) begin
        r = 8'(c);
        found = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/conv_start_arb.sv
module conv_start_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic idle,
  input  logic continuous,
  input  logic oneshot_req,
  input  logic pace_active,
  input  logic pace_tick,
  output logic fire
);
  logic os_pend, pace_pend;
  logic want_os, want_pace, want;

  assign want_os   = oneshot_req | os_pend;
  assign want_pace = pace_tick | pace_pend;
  // R3: one-shot ignored in continuous mode; R4/R5 pacing choice
  assign want = continuous ? (pace_active ? want_pace : 1'b1) : want_os;
  assign fire = enable & idle & want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_pend   <= 1'b0;
      pace_pend <= 1'b0;
    end else begin
      // R9: disabled drops pending requests
      if (!enable || continuous || fire) os_pend <= 1'b0;
      else if (oneshot_req)              os_pend <= 1'b1;
      if (!enable || !continuous || !pace_active || fire) pace_pend <= 1'b0;
      else if (pace_tick)                                 pace_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/conv_chan_step.sv
module conv_chan_step import conv_seq_pkg::*; #(
  parameter int NUM_CH = 9,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [NUM_CH-1:0] mask,
  input  logic [SEL_W-1:0]  done_chan,
  input  logic              sel_wr,
  input  logic [SEL_W-1:0]  sel_wr_data,
  output logic [SEL_W-1:0]  sel
);
  logic             step_en;
  logic [SEL_W-1:0] step_val;

  assign step_en  = accept && (mask != '0);
  assign step_val = SEL_W'(rr_next(MAX_CH'(mask), 8'(done_chan), NUM_CH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel <= '0;
    else if (step_en)  sel <= step_val;     // R12: step wins over write
    else if (sel_wr)   sel <= sel_wr_data;  // R1: zero mask keeps select
  end
endmodule

// File: rtl/conv_capture.sv
module conv_capture #(
  parameter int RES_W = 12,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [RES_W-1:0] result,
  input  logic             err,
  input  logic [SEL_W-1:0] chan,
  input  logic             err_clr,
  output logic [RES_W-1:0] last_result,
  output logic             last_err,
  output logic             err_sticky,
  output logic             smp_valid,
  output logic [RES_W-1:0] smp_result,
  output logic             smp_err,
  output logic [SEL_W-1:0] smp_chan
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_result <= '0;
      last_err    <= 1'b0;
      err_sticky  <= 1'b0;
      smp_valid   <= 1'b0;
      smp_result  <= '0;
      smp_err     <= 1'b0;
      smp_chan    <= '0;
    end else begin
      smp_valid <= accept;                  // R10
      if (accept) begin
        last_result <= result;              // R7
        last_err    <= err;
        smp_result  <= result;
        smp_err     <= err;
        smp_chan    <= chan;
      end
      if (accept && err)  err_sticky <= 1'b1;  // R8: set wins
      else if (err_clr)   err_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int NUM_CH = 9,
  parameter int SEL_W  = 4,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              continuous,
  input  logic              oneshot_req,
  input  logic              pace_active,
  input  logic              pace_tick,
  input  logic [NUM_CH-1:0] rr_mask,
  input  logic              sel_wr,
  input  logic [SEL_W-1:0]  sel_wr_data,
  input  logic              err_clr,
  output logic              conv_start,
  output logic [SEL_W-1:0]  conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  input  logic              conv_err,
  output logic              ready,
  output logic [SEL_W-1:0]  chan_sel,
  output logic [RES_W-1:0]  last_result,
  output logic              last_err,
  output logic              err_sticky,
  output logic              smp_valid,
  output logic [RES_W-1:0]  smp_result,
  output logic              smp_err,
  output logic [SEL_W-1:0]  smp_chan
);
  logic             busy;
  logic [SEL_W-1:0] cur_chan;
  logic             fire;
  logic             accept;

  // R11: done only counts while a conversion is in progress
  assign accept     = enable & busy & conv_done;
  assign ready      = enable & ~busy;        // R6, R9
  assign conv_start = fire;
  assign conv_chan  = busy ? cur_chan : chan_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_chan <= '0;
    end else begin
      if (!enable)     busy <= 1'b0;        // R9: abandon conversion
      else if (fire)   busy <= 1'b1;
      else if (accept) busy <= 1'b0;
      if (fire) cur_chan <= chan_sel;       // R2: sample current select
    end
  end

  conv_start_arb u_arb (
    .clk(clk), .rst_n(rst_n), .enable(enable), .idle(~busy),
    .continuous(continuous), .oneshot_req(oneshot_req),
    .pace_active(pace_active), .pace_tick(pace_tick), .fire(fire)
  );

  conv_chan_step #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_step (
    .clk(clk), .rst_n(rst_n), .accept(accept), .mask(rr_mask),
    .done_chan(cur_chan), .sel_wr(sel_wr), .sel_wr_data(sel_wr_data),
    .sel(chan_sel)
  );

  conv_capture #(.RES_W(RES_W), .SEL_W(SEL_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .accept(accept), .result(conv_result),
    .err(conv_err), .chan(cur_chan), .err_clr(err_clr),
    .last_result(last_result), .last_err(last_err), .err_sticky(err_sticky),
    .smp_valid(smp_valid), .smp_result(smp_result), .smp_err(smp_err),
    .smp_chan(smp_chan)
  );
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int NUM_CH = 9,
  parameter int SEL_W  = 4,
  parameter int RES_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [NUM_CH-1:0] rr_mask,
  input logic              sel_wr,
  input logic              conv_start,
  input logic              conv_done,
  input logic              ready,
  input logic [SEL_W-1:0]  chan_sel,
  input logic [RES_W-1:0]  last_result,
  input logic              err_sticky,
  input logic              smp_valid,
  input logic              smp_err
);
  a_r6_start_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ready);
  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !ready);
  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!conv_start && !ready));
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(last_result));
  a_r1_sel_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && ($past(rr_mask) == '0) && !$past(sel_wr)) |-> $stable(chan_sel));
  a_r8_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_err) |-> err_sticky);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && conv_done && !conv_start) |=> !smp_valid);
endmodule

bind conv_sequencer conv_sequencer_chk #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .rr_mask(rr_mask), .sel_wr(sel_wr),
  .conv_start(conv_start), .conv_done(conv_done), .ready(ready),
  .chan_sel(chan_sel), .last_result(last_result), .err_sticky(err_sticky),
  .smp_valid(smp_valid), .smp_err(smp_err)
);

// File: tb/test_conv_sequencer.sv
`timescale 1ns/1ps
module test_conv_sequencer;
  logic clk = 0, rst_n = 0;
  logic enable = 0, continuous = 0, oneshot_req = 0, pace_active = 0, pace_tick = 0;
  logic [8:0] rr_mask = '0;
  logic sel_wr = 0, err_clr = 0, conv_done = 0, conv_err = 0;
  logic [3:0] sel_wr_data = '0;
  logic [11:0] conv_result = '0;
  logic conv_start, ready, last_err, err_sticky, smp_valid, smp_err;
  logic [3:0] conv_chan, chan_sel, smp_chan;
  logic [11:0] last_result, smp_result;

  int checks = 0, errors = 0;
  int ref_sel = 0;
  int lastres = 0;

  always #10 clk = ~clk;  // 50 MHz

  conv_sequencer i_conv_sequencer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .continuous(continuous),
    .oneshot_req(oneshot_req), .pace_active(pace_active), .pace_tick(pace_tick),
    .rr_mask(rr_mask), .sel_wr(sel_wr), .sel_wr_data(sel_wr_data), .err_clr(err_clr),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_result(conv_result), .conv_err(conv_err), .ready(ready), .chan_sel(chan_sel),
    .last_result(last_result), .last_err(last_err), .err_sticky(err_sticky),
    .smp_valid(smp_valid), .smp_result(smp_result), .smp_err(smp_err), .smp_chan(smp_chan)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  function automatic int ref_next(input logic [8:0] m, input int cur);
    int k;
    k = 1;
    while (k <= 9) begin
      if (m[(cur + k) % 9]) return (cur + k) % 9;
      k++;
    end
    return cur;
  endfunction

  task automatic write_sel(input int v);
    sel_wr = 1; sel_wr_data = 4'(v);
    step();
    sel_wr = 0; #1;
    ref_sel = v;
    chk("R12 idle select write", chan_sel, v);
  endtask

  task automatic start_one();
    oneshot_req = 1; #1;
    chk("R3 one-shot start", conv_start, 1);
    chk("R2 channel at start", conv_chan, ref_sel);
    step();
    oneshot_req = 0; #1;
    chk("R6 not ready while busy", ready, 0);
  endtask

  task automatic finish(input int res, input bit e, input bit clr, input bit wr, input int wd);
    int conv_ch;
    conv_ch = ref_sel;
    conv_done = 1; conv_result = 12'(res); conv_err = e;
    err_clr = clr; sel_wr = wr; sel_wr_data = 4'(wd);
    step();
    conv_done = 0; err_clr = 0; sel_wr = 0; #1;
    chk("R10 sample pulse", smp_valid, 1);
    chk("R10 sample result", smp_result, res);
    chk("R10 sample channel", smp_chan, conv_ch);
    chk("R10 sample error", smp_err, e);
    chk("R7 last result", last_result, res);
    chk("R7 last error", last_err, e);
    if (rr_mask != 0) ref_sel = ref_next(rr_mask, conv_ch);
    else if (wr) ref_sel = wd;
    chk("R2 R1 select after completion", chan_sel, ref_sel);
    lastres = res;
  endtask

  task automatic t_reset();
    repeat (3) step();
    #1 chk("R6 ready in reset", ready, 0);
    rst_n = 1; step(); #1;
    chk("R9 ready while disabled", ready, 0);
    enable = 1; step(); #1;
    chk("R6 ready when idle", ready, 1);
  endtask

  task automatic t_oneshot_fixed();
    rr_mask = '0;
    write_sel(3);
    start_one();
    step(); step();
    finish(12'hABC, 0, 0, 0, 0);
    chk("R1 select fixed", chan_sel, 3);
    chk("R6 ready after completion", ready, 1);
    chk("R3 only one conversion", conv_start, 0);
    step(); #1;
    chk("R10 pulse one cycle", smp_valid, 0);
  endtask

  task automatic t_round_robin();
    rr_mask = 9'h112;
    write_sel(4);
    for (int i = 0; i < 3; i++) begin
      start_one();
      finish(100 + i, 0, 0, 0, 0);
    end
    chk("R2 wrapped to channel 4", chan_sel, 4);
    rr_mask = 9'h020;
    for (int i = 0; i < 2; i++) begin
      start_one();
      finish(200 + i, 0, 0, 0, 0);
    end
    chk("R2 single bit repeats", chan_sel, 5);
  endtask

  task automatic t_continuous();
    rr_mask = 9'h1FF;
    write_sel(0);
    continuous = 1; #1;
    chk("R4 continuous start", conv_start, 1);
    step(); #1;
    chk("R6 start drops when busy", conv_start, 0);
    step();
    finish(12'h111, 0, 0, 0, 0);
    chk("R4 back-to-back start", conv_start, 1);
    chk("R4 next channel presented", conv_chan, 1);
    step();
    continuous = 0; #1;
    finish(12'h222, 0, 0, 0, 0);
    chk("R4 stops when mode cleared", conv_start, 0);
  endtask

  task automatic t_paced();
    int seen;
    pace_active = 1; continuous = 1; oneshot_req = 1; #1;
    chk("R3 one-shot ignored in continuous", conv_start, 0);
    step();
    oneshot_req = 0;
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      #1 seen = seen | int'(conv_start);
      step();
    end
    chk("R5 no start without tick", seen, 0);
    pace_tick = 1; #1;
    chk("R5 start on tick", conv_start, 1);
    chk("R5 channel on tick", conv_chan, ref_sel);
    step();
    pace_tick = 0;
    step();
    pace_tick = 1;
    step();
    pace_tick = 0;
    finish(12'h333, 0, 0, 0, 0);
    chk("R5 held tick starts next", conv_start, 1);
    step();
    continuous = 0; pace_active = 0; #1;
    finish(12'h444, 0, 0, 0, 0);
    chk("R3 no start after continuous", conv_start, 0);
  endtask

  task automatic t_errors();
    rr_mask = '0;
    start_one();
    finish(12'h055, 1, 0, 0, 0);
    chk("R8 sticky set", err_sticky, 1);
    start_one();
    finish(12'h066, 0, 0, 0, 0);
    chk("R7 error only latest", last_err, 0);
    chk("R8 sticky kept", err_sticky, 1);
    err_clr = 1; step(); err_clr = 0; #1;
    chk("R8 sticky cleared", err_sticky, 0);
    start_one();
    finish(12'h077, 1, 1, 0, 0);
    chk("R8 set wins over clear", err_sticky, 1);
    err_clr = 1; step(); err_clr = 0; #1;
    chk("R8 cleared again", err_sticky, 0);
  endtask

  task automatic t_pending_enable();
    start_one();
    oneshot_req = 1; step(); oneshot_req = 0;
    finish(12'h088, 0, 0, 0, 0);
    chk("R3 held one-shot starts", conv_start, 1);
    step();
    finish(12'h099, 0, 0, 0, 0);
    enable = 0; oneshot_req = 1; #1;
    chk("R9 no start when disabled", conv_start, 0);
    chk("R9 not ready when disabled", ready, 0);
    step();
    oneshot_req = 0; enable = 1; step(); #1;
    chk("R9 request dropped", conv_start, 0);
    start_one();
    oneshot_req = 1; step(); oneshot_req = 0;
    enable = 0; step(); enable = 1; #1;
    chk("R9 ready after re-enable", ready, 1);
    chk("R9 pending dropped", conv_start, 0);
    conv_done = 1; conv_result = 12'hFFF; step(); conv_done = 0; #1;
    chk("R11 done ignored no pulse", smp_valid, 0);
    chk("R11 result unchanged", last_result, lastres);
  endtask

  task automatic t_sel_collision();
    rr_mask = 9'h003;
    write_sel(0);
    start_one();
    finish(12'h123, 0, 0, 1, 7);
    chk("R12 step wins over write", chan_sel, 1);
    write_sel(7);
  endtask

  initial begin
    t_reset();
    t_oneshot_fixed();
    t_round_robin();
    t_continuous();
    t_paced();
    t_errors();
    t_pending_enable();
    t_sel_collision();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule